// File: doc/BRIEF.md
# Dual-Slope PWM Timer with Buffered Compare Channels

This block is a 16-bit timer that counts up from zero to a ceiling and then back down, which gives a symmetric, centre-aligned PWM waveform. Each compare channel takes its new threshold into a shadow register. The shadow value moves into the live compare register only while the counter sits at zero, so a new duty cycle or period always starts on a clean period boundary. The ceiling comes either from its own register or from channel 0's live compare value. Because that value also changes only at zero, the period is updated without glitches as well.

All state runs on the one system clock. A prescaler produces a count-enable pulse at one of three rates, or it holds the counter still. Each channel drives one output pin in one of four modes: off, toggle on match, PWM, or inverted PWM. Each channel also raises a sticky match flag, which software clears by writing a one to it. A simple write-only register port loads the ceiling, the shadow compare values, the control word and the rate select.

Top module: `dual_slope_pwm`

## Requirements
- R1: After reset the counter reads 0, every output pin is low and every match flag is clear.
- R2: With ceiling T > 0, each count enable moves the counter one step. The value climbs 0,1,..,T and then falls T-1,..,1,0, and the pattern repeats every 2*T enables, with 0 and T each held for one enable per period. A ceiling of 0 keeps the counter at 0.
- R3: Rate select (address 2, bits [1:0]): 0 stops counting, 1 enables every clock, 2 every 8th clock and 3 every 64th clock. Writing the select restarts the divider, and the counter changes only on an enabled clock.
- R4: A write to a channel's shadow register (address 4+channel) has no effect on matching until an enabled clock with the counter at 0, which copies the shadow value into the live register. A live value above the ceiling never matches.
- R5: A channel's flag goes high on the clock edge that ends the enabled cycle in which the counter equals the live compare value. It is still low while the counter shows that value.
- R6: A flag stays high until a write to address 3 has a 1 in that channel's bit position. Zero bits leave flags unchanged, and a new match in the same cycle wins over the clear.
- R7: In PWM mode (code 2) with live compare c, 0 <= c <= T, the pin is high for exactly 2*c of every 2*T enables. c = 0 holds the pin low and c = T holds it high. The pin falls on a match while climbing below the ceiling and rises on any other match.
- R8: Inverted PWM (code 3) drives the exact complement of the code-2 waveform.
- R9: Toggle mode (code 1) inverts the pin on every match. With channel 0 setting the ceiling, this gives a square wave of 50% duty with a period of 4*T enables.
- R10: Control register (address 1): bit 0 set makes channel 0's live compare the ceiling in place of the ceiling register (address 0). Channel n's pin mode sits in bits [2n+2:2n+1].
- R11: Mode code 0 holds the pin low whatever the counter does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register address |
| wr_data | input | W (16) | Register write data |
| pwm_o | output | NCH (2) | Channel output pins |
| flag_o | output | NCH (2) | Sticky compare-match flags |
| count_o | output | W (16) | Current counter value |

## Verification
A wrong direction bit or a slip at a turning point shows on `count_o` within one enable, because the triangle loses its shape. The same fault also breaks the high count measured on each pin within one period. A live compare register that loads too early raises a flag while the counter is still on the far side of zero. That is visible within half a period of the shadow write. A wrong level or a missing complement changes the number of high cycles that each full 2*T window accumulates, so sweeping every compare value from 0 to T shows it after one period per value.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
   typedef enum logic [1:0] {
      PIN_OFF     = 2'd0,
      PIN_TOGGLE  = 2'd1,
      PIN_PWM     = 2'd2,
      PIN_PWM_INV = 2'd3
   } pin_mode_e;

   typedef enum logic [1:0] {
      CLK_STOP = 2'd0,
      CLK_DIV1 = 2'd1,
      CLK_DIVB = 2'd2,
      CLK_DIVC = 2'd3
   } clk_sel_e;

   localparam int unsigned REG_TOP      = 0;
   localparam int unsigned REG_CTRL     = 1;
   localparam int unsigned REG_CLK      = 2;
   localparam int unsigned REG_FLAGS    = 3;
   localparam int unsigned REG_CMP_BASE = 4;
endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler
   import pwmt_pkg::*;
#(
   parameter int unsigned DIV_B_LOG = 3,
   parameter int unsigned DIV_C_LOG = 6
) (
   input  logic     clk,
   input  logic     rst_n,
   input  clk_sel_e sel,
   input  logic     restart,
   output logic     tick
);
   localparam int unsigned PW = DIV_C_LOG;

   logic [PW-1:0] div_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       div_q <= '0;
      else if (restart) div_q <= '0;
      else              div_q <= div_q + 1'b1;
   end

   always_comb begin
      unique case (sel)
         CLK_STOP: tick = 1'b0;
         CLK_DIV1: tick = 1'b1;
         CLK_DIVB: tick = &div_q[DIV_B_LOG-1:0];
         CLK_DIVC: tick = &div_q;
         default:  tick = 1'b0;
      endcase
   end

   AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == CLK_STOP) |-> !tick); // R3
   AST_DIV1_EVERY_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == CLK_DIV1) |-> tick); // R3
endmodule

// File: rtl/pwmt_updown.sv
module pwmt_updown #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] top,
   output logic [W-1:0] cnt,
   output logic         dir_up
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         dir_up <= 1'b1;
      end else if (tick) begin
         if (top == '0) begin
            cnt    <= '0;
            dir_up <= 1'b1;
         end else if (dir_up) begin
            if (cnt >= top) begin
               dir_up <= 1'b0;
               cnt    <= cnt - 1'b1;
            end else begin
               cnt    <= cnt + 1'b1;
            end
         end else begin
            if (cnt == '0) begin
               dir_up <= 1'b1;
               cnt    <= cnt + 1'b1;
            end else begin
               cnt    <= cnt - 1'b1;
            end
         end
      end
   end

   AST_HOLD_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt)); // R3
   AST_CLIMB_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && dir_up && cnt < top) |=> (cnt == $past(cnt) + 1'b1)); // R2
   AST_TURN_AT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && dir_up && top != '0 && cnt == top) |=> !dir_up); // R2
endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
   import pwmt_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] cnt,
   input  logic         dir_up,
   input  logic [W-1:0] top,
   input  logic         buf_we,
   input  logic [W-1:0] buf_d,
   input  pin_mode_e    mode,
   input  logic         flag_clr,
   output logic         pin,
   output logic         flag,
   output logic [W-1:0] active
);
   logic [W-1:0] shadow_q;
   logic [W-1:0] act_q;
   logic         lvl_q;
   logic         tgl_q;
   logic         flag_q;
   logic         hit;
   logic         lvl_next;

   assign hit = tick && (cnt == act_q);

   always_comb begin
      if (act_q == '0)                 lvl_next = 1'b0;
      else if (dir_up && cnt != top)   lvl_next = 1'b0;
      else                             lvl_next = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_q <= '1;
         act_q    <= '1;
         lvl_q    <= 1'b0;
         tgl_q    <= 1'b0;
         flag_q   <= 1'b0;
      end else begin
         if (buf_we) shadow_q <= buf_d;
         if (tick && cnt == '0) act_q <= shadow_q;
         if (hit) begin
            lvl_q <= lvl_next;
            tgl_q <= ~tgl_q;
         end
         if (hit)           flag_q <= 1'b1;
         else if (flag_clr) flag_q <= 1'b0;
      end
   end

   always_comb begin
      unique case (mode)
         PIN_OFF:     pin = 1'b0;
         PIN_TOGGLE:  pin = tgl_q;
         PIN_PWM:     pin = lvl_q;
         PIN_PWM_INV: pin = ~lvl_q;
         default:     pin = 1'b0;
      endcase
   end

   assign flag   = flag_q;
   assign active = act_q;

   AST_LIVE_LOADS_AT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick && cnt == '0) |=> $stable(act_q)); // R4
   AST_FLAG_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag_q); // R5
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !flag_clr) |=> flag_q); // R6
   AST_ZERO_CMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && act_q == '0) |=> !lvl_q); // R7
endmodule

// File: rtl/dual_slope_pwm.sv
module dual_slope_pwm
   import pwmt_pkg::*;
#(
   parameter int unsigned W         = 16,
   parameter int unsigned NCH       = 2,
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned DIV_B_LOG = 3,
   parameter int unsigned DIV_C_LOG = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [W-1:0]      wr_data,
   output logic [NCH-1:0]    pwm_o,
   output logic [NCH-1:0]    flag_o,
   output logic [W-1:0]      count_o
);
   localparam int unsigned CTRL_BITS = 2 * NCH + 1;

   if (NCH < 1 || NCH > 4) begin : g_bad_nch
      $error("dual_slope_pwm: NCH must be 1..4");
   end
   if (CTRL_BITS > W) begin : g_bad_w
      $error("dual_slope_pwm: W too narrow for the control word");
   end
   if (REG_CMP_BASE + NCH > (1 << ADDR_W)) begin : g_bad_addr
      $error("dual_slope_pwm: ADDR_W too small for the register map");
   end
   if (DIV_B_LOG < 1 || DIV_C_LOG <= DIV_B_LOG) begin : g_bad_div
      $error("dual_slope_pwm: divider exponents must rise");
   end

   logic [W-1:0]         top_q;
   logic [CTRL_BITS-1:0] ctrl_q;
   clk_sel_e             clk_q;
   logic                 tick;
   logic                 clk_restart;
   logic [W-1:0]         top_eff;
   logic [W-1:0]         cnt;
   logic                 dir_up;
   logic [W-1:0]         act [NCH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         top_q  <= '0;
         ctrl_q <= '0;
         clk_q  <= CLK_STOP;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(REG_TOP))  top_q  <= wr_data;
         if (wr_addr == ADDR_W'(REG_CTRL)) ctrl_q <= wr_data[CTRL_BITS-1:0];
         if (wr_addr == ADDR_W'(REG_CLK))  clk_q  <= clk_sel_e'(wr_data[1:0]);
      end
   end

   assign clk_restart = wr_en && (wr_addr == ADDR_W'(REG_CLK));
   assign top_eff     = ctrl_q[0] ? act[0] : top_q;

   pwmt_prescaler #(
      .DIV_B_LOG (DIV_B_LOG),
      .DIV_C_LOG (DIV_C_LOG)
   ) i_prescaler (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (clk_q),
      .restart (clk_restart),
      .tick    (tick)
   );

   pwmt_updown #(
      .W (W)
   ) i_updown (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .top    (top_eff),
      .cnt    (cnt),
      .dir_up (dir_up)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      pin_mode_e ch_mode;
      logic      ch_we;
      logic      ch_clr;

      assign ch_mode = pin_mode_e'(ctrl_q[2*c+2 -: 2]);
      assign ch_we   = wr_en && (wr_addr == ADDR_W'(REG_CMP_BASE + c));
      assign ch_clr  = wr_en && (wr_addr == ADDR_W'(REG_FLAGS)) && wr_data[c];

      pwmt_channel #(
         .W (W)
      ) i_channel (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (tick),
         .cnt      (cnt),
         .dir_up   (dir_up),
         .top      (top_eff),
         .buf_we   (ch_we),
         .buf_d    (wr_data),
         .mode     (ch_mode),
         .flag_clr (ch_clr),
         .pin      (pwm_o[c]),
         .flag     (flag_o[c]),
         .active   (act[c])
      );

      AST_OFF_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_mode == PIN_OFF) |-> !pwm_o[c]); // R11
   end

   assign count_o = cnt;

   AST_COUNT_CHANGES_ONLY_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_q == CLK_STOP && !clk_restart) |=> $stable(count_o)); // R3
endmodule

// File: tb/test_dual_slope_pwm.sv
module test_dual_slope_pwm;
   localparam int W = 16;
   localparam int NCH = 2;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic [NCH-1:0] pwm_o;
   logic [NCH-1:0] flag_o;
   logic [W-1:0]  count_o;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   dual_slope_pwm #(.W(W), .NCH(NCH), .ADDR_W(AW)) i_dual_slope_pwm (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .pwm_o   (pwm_o),
      .flag_o  (flag_o),
      .count_o (count_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic wr(input int a, input int d);
      wr_en   = 1'b1;
      wr_addr = AW'(a);
      wr_data = W'(d);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wait_cnt(input int v);
      while (int'(count_o) != v) @(negedge clk);
   endtask

   function automatic int tri_val(input int k, input int t);
      int m;
      m = k % (2 * t);
      return (m <= t) ? m : 2 * t - m;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int prev;
      int n;
      int hi0;
      int hi1;
      int mx;
      int bad;

      repeat (4) @(negedge clk);
      chk(count_o == '0, "R1 count", int'(count_o), 0);
      chk(pwm_o == '0, "R1 pins", int'(pwm_o), 0);
      chk(flag_o == '0, "R1 flags", int'(flag_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: triangle with ceiling 5
      wr(0, 5);
      wr(1, 'h1C);
      wr(2, 1);
      chk(count_o == '0, "R2 start", int'(count_o), 0);
      for (int k = 1; k <= 24; k++) begin
         @(negedge clk);
         chk(int'(count_o) == tri_val(k, 5), "R2 sequence", int'(count_o), tri_val(k, 5));
      end

      // R3: divide by 8, then stop
      wr(2, 2);
      prev = int'(count_o);
      n = 0;
      for (int k = 0; k < 64; k++) begin
         @(negedge clk);
         if (int'(count_o) != prev) n++;
         prev = int'(count_o);
      end
      chk(n == 8, "R3 div8 steps", n, 8);
      wr(2, 0);
      prev = int'(count_o);
      n = 0;
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         if (int'(count_o) != prev) n++;
      end
      chk(n == 0, "R3 stopped", n, 0);

      // R7 / R8: sweep every compare value with ceiling 10
      wr(0, 10);
      wr(2, 1);
      for (int c = 0; c <= 10; c++) begin
         wr(4, c);
         wr(5, c);
         repeat (60) @(negedge clk);
         hi0 = 0;
         hi1 = 0;
         for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            hi0 += int'(pwm_o[0]);
            hi1 += int'(pwm_o[1]);
         end
         chk(hi0 == 2 * c, "R7 duty", hi0, 2 * c);
         chk(hi1 == 20 - 2 * c, "R8 inverted duty", hi1, 20 - 2 * c);
      end

      // R4: shadow write waits for bottom
      wr(5, 15);
      repeat (40) @(negedge clk);
      prev = int'(count_o);
      @(negedge clk);
      while (!(int'(count_o) == 3 && prev == 2)) begin
         prev = int'(count_o);
         @(negedge clk);
      end
      wr(5, 8);
      wr(3, 2);
      wait_cnt(2);
      chk(flag_o[1] == 1'b0, "R4 no early match", int'(flag_o[1]), 0);
      wait_cnt(9);
      chk(flag_o[1] == 1'b1, "R4 match after bottom", int'(flag_o[1]), 1);

      // R5: flag timing at full rate
      wait_cnt(5);
      wr(3, 2);
      wait_cnt(8);
      chk(flag_o[1] == 1'b0, "R5 flag while at match", int'(flag_o[1]), 0);
      @(negedge clk);
      chk(flag_o[1] == 1'b1, "R5 flag next edge", int'(flag_o[1]), 1);

      // R6: sticky and clear-by-one
      repeat (30) @(negedge clk);
      chk(flag_o[1] == 1'b1, "R6 sticky", int'(flag_o[1]), 1);
      wr(3, 1);
      chk(flag_o[1] == 1'b1, "R6 zero bit ignored", int'(flag_o[1]), 1);
      wait_cnt(2);
      wr(3, 2);
      chk(flag_o[1] == 1'b0, "R6 cleared", int'(flag_o[1]), 0);

      // R5: flag timing with divide by 8
      wr(2, 2);
      wait_cnt(3);
      wr(3, 2);
      wait_cnt(8);
      bad = 0;
      while (int'(count_o) == 8) begin
         if (flag_o[1]) bad++;
         @(negedge clk);
      end
      chk(bad == 0, "R5 div8 flag early", bad, 0);
      chk(flag_o[1] == 1'b1, "R5 div8 flag set", int'(flag_o[1]), 1);

      // R9 / R10: ceiling from channel 0, toggle
      wr(2, 1);
      wr(4, 6);
      wr(5, 6);
      wr(1, 'h13);
      repeat (60) @(negedge clk);
      hi0 = 0;
      hi1 = 0;
      n = 0;
      mx = 0;
      prev = int'(pwm_o[0]);
      for (int k = 0; k < 48; k++) begin
         @(negedge clk);
         hi0 += int'(pwm_o[0]);
         hi1 += int'(pwm_o[1]);
         if (int'(pwm_o[0]) != prev) n++;
         prev = int'(pwm_o[0]);
         if (int'(count_o) > mx) mx = int'(count_o);
      end
      chk(hi0 == 24, "R9 square duty", hi0, 24);
      chk(n == 4, "R9 toggles", n, 4);
      chk(mx == 6, "R10 ceiling from channel 0", mx, 6);
      chk(hi1 == 48, "R7 compare at ceiling", hi1, 48);

      // R11: mode off
      wr(1, 'h03);
      hi1 = 0;
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         hi1 += int'(pwm_o[1]);
      end
      chk(hi1 == 0, "R11 off low", hi1, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule